// File: doc/BRIEF.md
# Bit-plane front end for a parallel distributed-arithmetic FIR filter

This block sits ahead of the coefficient tables in a fully parallel distributed-arithmetic FIR filter. Every clock it takes one new sample, signed or unsigned, and pushes it into a register delay line of `TAPS` stages. When the filter's coefficients are mirror-symmetric, it adds the two taps that share a coefficient. This folds the line into about half as many lanes, each one bit wider than a sample. The lane values are then regrouped by bit weight: output word b holds bit b of every lane. That word is the address of the distributed-arithmetic table that serves bit weight 2^b.

A small two-state controller tracks the filling of the delay line. It starts in `ST_FILL` after reset. It moves to `ST_RUN` on the clock edge that loads the `TAPS`-th sample (transition FILL_DONE) and then stays in `ST_RUN` (transition HOLD) until the next reset. The valid flag is a registered copy of "state is `ST_RUN`". Its timing therefore matches that of the lane register, which is the block's output stage.

With `SYMMETRIC` cleared, no adders are built. The lanes are the raw taps and the block emits `SAMPLE_W` words of `TAPS` bits.

Top module: `fir_bitplane_front`

## Requirements
- R1: While `rst` is high, `valid_o` is low and every bit of `planes_o` is zero on the following clock edge.
- R2: `valid_o` is low until the edge after the `TAPS`-th sample following reset has been captured. It rises on that edge, which is the (`TAPS`+1)-th rising edge after reset release, and then stays high until reset.
- R3: The delay line shifts on every clock. Tap n holds the sample captured n clock edges before the sample now in tap 0.
- R4: In symmetric mode, lane i for i in 0..`TAPS`/2-1 equals tap i plus tap `TAPS`-1-i, computed in `SAMPLE_W`+1 bits without loss.
- R5: When `IS_SIGNED`=1, taps are sign-extended by one bit before the add (two's complement). When `IS_SIGNED`=0, they are zero-extended.
- R6: In symmetric mode with an odd `TAPS`, the last lane (index `TAPS`/2) is the centre tap alone, extended to `SAMPLE_W`+1 bits under the rule of R5.
- R7: `planes_o` packs word b in bits [b*WORD_W +: WORD_W]. Bit i of word b is bit b of lane i. In symmetric mode WORD_W=(`TAPS`+1)/2 and there are `SAMPLE_W`+1 words. Word `SAMPLE_W` carries the extra top bit of each sum.
- R8: The lane values are registered. The word seen after edge E is built from the taps as they stood after edge E-1.
- R9: With `SYMMETRIC`=0, lane i is tap i unextended, WORD_W=`TAPS`, and there are `SAMPLE_W` words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | SAMPLE_W | New sample, captured on every rising edge |
| planes_o | output | WORDS*WORD_W | Bit-plane words, word b at [b*WORD_W +: WORD_W] |
| valid_o | output | 1 | High once the delay line is full |

## Verification
A sample captured on edge j reaches tap n on edge j+n and appears in the output words after edge j+n+1. The first valid word is produced by edge `TAPS`+1. The bench records every driven sample under the edge that captures it. It counts edges after reset and reads the outputs at the falling edge that follows edge E. It compares them with lanes rebuilt from the samples of edges E-1-n. Valid is expected low for E up to `TAPS` and high from `TAPS`+1 on. Three instances run side by side: odd symmetric signed, even symmetric unsigned, and unfolded. The expected rise edge therefore differs for each instance.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } fill_state_t;
endpackage

// File: rtl/fbp_delay_line.sv
module fbp_delay_line #(
    parameter int W = 8,
    parameter int N = 7
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   din,
    output logic [N*W-1:0] taps_o
);
    logic [W-1:0] stage [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) stage[k] <= '0;
        end else begin
            stage[0] <= din;
            for (int k = 1; k < N; k++) stage[k] <= stage[k-1];
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_flat
        assign taps_o[g*W +: W] = stage[g];
    end
endmodule

// File: rtl/fbp_lane_stage.sv
module fbp_lane_stage #(
    parameter int B   = 8,
    parameter int N   = 7,
    parameter bit SYM = 1'b1,
    parameter bit SGN = 1'b1,
    localparam int LANES = SYM ? (N + 1) / 2 : N,
    localparam int LW    = SYM ? B + 1 : B
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N*B-1:0]     taps_i,
    output logic [LANES*LW-1:0] lanes_o
);
    localparam int PAIRS = N / 2;

    logic [LW-1:0] lane_d [LANES];

    if (SYM) begin : g_fold
        for (genvar i = 0; i < PAIRS; i++) begin : g_pair
            logic [B-1:0] near_t, far_t;
            logic [B:0]   near_x, far_x;
            assign near_t = taps_i[i*B +: B];
            assign far_t  = taps_i[(N-1-i)*B +: B];
            assign near_x = {SGN & near_t[B-1], near_t};
            assign far_x  = {SGN & far_t[B-1], far_t};
            assign lane_d[i] = near_x + far_x;
        end
        if (N % 2 == 1) begin : g_centre
            logic [B-1:0] mid_t;
            assign mid_t = taps_i[PAIRS*B +: B];
            assign lane_d[PAIRS] = {SGN & mid_t[B-1], mid_t};
        end
    end else begin : g_plain
        for (genvar i = 0; i < N; i++) begin : g_tap
            assign lane_d[i] = taps_i[i*B +: B];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lanes_o <= '0;
        end else begin
            for (int i = 0; i < LANES; i++) lanes_o[i*LW +: LW] <= lane_d[i];
        end
    end
endmodule

// File: rtl/fbp_transpose.sv
module fbp_transpose #(
    parameter int LW    = 9,
    parameter int LANES = 4
) (
    input  logic [LANES*LW-1:0] lanes_i,
    output logic [LW*LANES-1:0] words_o
);
    for (genvar b = 0; b < LW; b++) begin : g_word
        for (genvar i = 0; i < LANES; i++) begin : g_bit
            assign words_o[b*LANES + i] = lanes_i[i*LW + b];
        end
    end
endmodule

// File: rtl/fbp_fill_ctrl.sv
module fbp_fill_ctrl #(
    parameter int N = 7
) (
    input  logic clk,
    input  logic rst,
    output logic valid_o
);
    import fbp_pkg::*;

    localparam int CW = $clog2(N + 1);

    fill_state_t state, state_nxt;
    logic [CW-1:0] fill_cnt, fill_cnt_nxt;

    always_comb begin
        state_nxt    = state;
        fill_cnt_nxt = fill_cnt;
        unique case (state)
            ST_FILL: begin
                fill_cnt_nxt = fill_cnt + 1'b1;
                if (fill_cnt == CW'(N - 1)) state_nxt = ST_RUN;
            end
            ST_RUN: begin
                state_nxt = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_FILL;
            fill_cnt <= '0;
        end else begin
            state    <= state_nxt;
            fill_cnt <= fill_cnt_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) valid_o <= 1'b0;
        else     valid_o <= (state == ST_RUN);
    end
endmodule

// File: rtl/fir_bitplane_front.sv
module fir_bitplane_front #(
    parameter int SAMPLE_W  = 8,
    parameter int TAPS      = 7,
    parameter bit SYMMETRIC = 1'b1,
    parameter bit IS_SIGNED = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [(SYMMETRIC ? (SAMPLE_W+1)*((TAPS+1)/2) : SAMPLE_W*TAPS)-1:0] planes_o,
    output logic valid_o
);
    localparam int LANES = SYMMETRIC ? (TAPS + 1) / 2 : TAPS;
    localparam int LW    = SYMMETRIC ? SAMPLE_W + 1 : SAMPLE_W;

    logic [TAPS*SAMPLE_W-1:0] taps;
    logic [LANES*LW-1:0]      lanes;

    fbp_delay_line #(.W(SAMPLE_W), .N(TAPS)) u_line (
        .clk(clk), .rst(rst), .din(sample_i), .taps_o(taps)
    );

    fbp_lane_stage #(.B(SAMPLE_W), .N(TAPS), .SYM(SYMMETRIC), .SGN(IS_SIGNED)) u_lanes (
        .clk(clk), .rst(rst), .taps_i(taps), .lanes_o(lanes)
    );

    fbp_transpose #(.LW(LW), .LANES(LANES)) u_xpose (
        .lanes_i(lanes), .words_o(planes_o)
    );

    fbp_fill_ctrl #(.N(TAPS)) u_fill (
        .clk(clk), .rst(rst), .valid_o(valid_o)
    );
endmodule

// File: rtl/fbp_checker.sv
module fbp_checker #(
    parameter int B   = 8,
    parameter int N   = 7,
    parameter bit SYM = 1'b1,
    parameter int PW  = 36
) (
    input logic          clk,
    input logic          rst,
    input logic [B-1:0]  din,
    input logic [PW-1:0] planes,
    input logic          valid
);
    localparam int LANES = SYM ? (N + 1) / 2 : N;
    localparam int LW    = SYM ? B + 1 : B;
    localparam int LIM   = N + 3;
    localparam int CW    = $clog2(LIM + 1);

    logic [CW-1:0] cyc;
    always_ff @(posedge clk) begin
        if (rst)                cyc <= '0;
        else if (cyc < CW'(LIM)) cyc <= cyc + 1'b1;
    end

    logic [LW-1:0] lane0;
    for (genvar b = 0; b < LW; b++) begin : g_l0
        assign lane0[b] = planes[b*LANES];
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> (!valid && planes == '0));

    // R2
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst) valid |=> valid);

    // R2
    valid_rise_time_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> (cyc == CW'(N + 1)));

    if (!SYM) begin : g_plain_chk
        // R3
        tap0_path_chk: assert property (@(posedge clk) disable iff (rst)
            (cyc >= CW'(3)) |-> (lane0 == $past(din, 2)));
    end
endmodule

bind fir_bitplane_front fbp_checker #(
    .B(SAMPLE_W), .N(TAPS), .SYM(SYMMETRIC),
    .PW(SYMMETRIC ? (SAMPLE_W+1)*((TAPS+1)/2) : SAMPLE_W*TAPS)
) u_fbp_chk (
    .clk(clk), .rst(rst), .din(sample_i), .planes(planes_o), .valid(valid_o)
);

// File: tb/fir_bitplane_front_bench.sv
module fir_bitplane_front_bench;
    localparam int B = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [B-1:0] sample_i = '0;
    always #5 clk = ~clk;

    logic [35:0] pa; logic va;   // 7 taps, symmetric, signed
    logic [26:0] pb; logic vb;   // 6 taps, symmetric, unsigned
    logic [39:0] pc; logic vc;   // 5 taps, unfolded

    fir_bitplane_front #(.SAMPLE_W(B), .TAPS(7), .SYMMETRIC(1'b1), .IS_SIGNED(1'b1)) u_fir_bitplane_front (
        .clk(clk), .rst(rst), .sample_i(sample_i), .planes_o(pa), .valid_o(va));
    fir_bitplane_front #(.SAMPLE_W(B), .TAPS(6), .SYMMETRIC(1'b1), .IS_SIGNED(1'b0)) u_fir_bitplane_front_even (
        .clk(clk), .rst(rst), .sample_i(sample_i), .planes_o(pb), .valid_o(vb));
    fir_bitplane_front #(.SAMPLE_W(B), .TAPS(5), .SYMMETRIC(1'b0), .IS_SIGNED(1'b0)) u_fir_bitplane_front_flat (
        .clk(clk), .rst(rst), .sample_i(sample_i), .planes_o(pc), .valid_o(vc));

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [B-1:0] s [0:1023];

    function automatic int ext(logic [B-1:0] x, bit sgn);
        return sgn ? int'($signed(x)) : int'(x);
    endfunction

    // Expected words after edge E: lanes from samples captured at edges E-1-n
    function automatic logic [127:0] exp_planes(int nt, bit sym, bit sgn, int e);
        logic [127:0] r = '0;
        int words = sym ? (nt + 1) / 2 : nt;
        int lw = sym ? B + 1 : B;
        for (int i = 0; i < words; i++) begin
            int v;
            if (!sym)              v = int'(s[e-1-i]);
            else if (i < nt / 2)   v = ext(s[e-1-i], sgn) + ext(s[e-1-(nt-1-i)], sgn);
            else                   v = ext(s[e-1-i], sgn);
            for (int b = 0; b < lw; b++) r[b*words + i] = v[b];
        end
        return r;
    endfunction

    task automatic check(string tag, bit ok, logic [127:0] got, logic [127:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, expv);
        end
    endtask

    task automatic check_inst(string name, int nt, bit sym, bit sgn, int e, logic v, logic [127:0] got);
        if (e < nt + 1) begin
            check({name, " R2 valid low while filling"}, v == 1'b0, 128'(v), 128'd0);
        end else begin
            logic [127:0] x = exp_planes(nt, sym, sgn, e);
            check({name, " R2 valid high after fill"}, v == 1'b1, 128'(v), 128'd1);
            if (sym)
                check({name, " R4 R5 R6 R7 R8 folded words"}, got == x, got, x);
            else
                check({name, " R3 R8 R9 unfolded words"}, got == x, got, x);
        end
    endtask

    function automatic logic [B-1:0] gen(int j);
        if (j <= 10) return 8'h80;                  // most negative / large unsigned
        if (j <= 20) return 8'h7F;                  // most positive
        if (j <= 30) return j[0] ? 8'hFF : 8'h01;   // alternating ends
        return 8'($urandom);
    endfunction

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        check("R1 reset valid a", va == 1'b0, 128'(va), 128'd0);
        check("R1 reset words a", pa == '0, 128'(pa), 128'd0);
        check("R1 reset words b", pb == '0 && vb == 1'b0, 128'(pb), 128'd0);
        check("R1 reset words c", pc == '0 && vc == 1'b0, 128'(pc), 128'd0);
        rst = 1'b0;
        s[1] = gen(1);
        sample_i = s[1];
        for (int e = 1; e <= 400; e++) begin
            @(posedge clk);
            @(negedge clk);
            check_inst("odd-signed", 7, 1'b1, 1'b1, e, va, 128'(pa));
            check_inst("even-unsigned", 6, 1'b1, 1'b0, e, vb, 128'(pb));
            check_inst("flat", 5, 1'b0, 1'b0, e, vc, 128'(pc));
            s[e+1] = gen(e + 1);
            sample_i = s[e+1];
        end
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule